// File: doc/BRIEF.md
# Registered Two-Path Arithmetic and Logic Unit

This block combines a bitwise logic path and an add/subtract path behind one 2-bit function code. A mode input chooses the path. The logic path forms AND, OR, XOR or the complement of operand A. The arithmetic path uses a single ripple-carry adder for four operations. A small addend generator feeds that adder with B, the inverse of B, all zeros or all ones, and sets the matching carry-in. With these inputs the one adder performs addition, two's-complement subtraction, increment and decrement.

The result of the chosen path goes through a 2-to-1 selector and is held in a register that loads on every rising clock edge. A carry flag is registered next to the result. The operand width is a parameter with a default of 4. The target clock is 200 MHz, so the longest path runs from the addend generator through the carry ripple and the selector into the register.

Top module: `dual_path_alu`

## Requirements
- R1: With mode = 0 and sel = 2'b00, the result one clock edge later is the bitwise AND of a and b.
- R2: With mode = 0 and sel = 2'b01, the result is the bitwise OR of a and b.
- R3: With mode = 0 and sel = 2'b10, the result is the bitwise complement of a, and b has no effect on it.
- R4: With mode = 0 and sel = 2'b11, the result is the bitwise XOR of a and b.
- R5: With mode = 1 and sel = 2'b00, the result is (a + b) mod 2^W, and carry_out is bit W of the full sum.
- R6: With mode = 1 and sel = 2'b01, the result is (a - b) mod 2^W, and carry_out is 1 exactly when a >= b, taken as unsigned values.
- R7: With mode = 1 and sel = 2'b10, the result is (a + 1) mod 2^W, and carry_out is 1 exactly when a is all ones.
- R8: With mode = 1 and sel = 2'b11, the result is (a - 1) mod 2^W, and carry_out is 1 exactly when a is nonzero.
- R9: When mode = 0, carry_out is 0 after the next clock edge.
- R10: result and carry_out change only on a rising clock edge. They reflect the inputs sampled at the most recent edge, so a change on the inputs between edges leaves them unchanged.
- R11: rst is active-high and synchronous. A rising edge with rst = 1 clears result and carry_out to 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 selects the logic path, 1 selects the arithmetic path |
| sel | input | 2 | Function code, read according to mode |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Registered result |
| carry_out | output | 1 | Registered adder carry; 0 in logic mode |

## Verification
The hardest case to reach is a carry that ripples across the full width and sets the carry flag. This happens for subtraction with equal operands, increment of all ones and decrement of one, where a single wrong carry-in or a wrong inverted addend changes only the flag or only the top bit. The stimulus walks every mode, function code and pair of 4-bit operands, which covers each of these edges. A short table of hand-picked vectors then pins the wrap-around values explicitly. Directed steps change the inputs between edges and assert reset while other operations are requested.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Function codes in logic mode
  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_NOTA = 2'b10,
    LF_XOR  = 2'b11
  } logic_fn_e;

  // Function codes in arithmetic mode
  typedef enum logic [1:0] {
    AF_ADD = 2'b00,
    AF_SUB = 2'b01,
    AF_INC = 2'b10,
    AF_DEC = 2'b11
  } arith_fn_e;

  localparam logic MODE_LOGIC = 1'b0;
  localparam logic MODE_ARITH = 1'b1;

endpackage

// File: rtl/bitwise_unit.sv
module bitwise_unit
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic_fn_e      fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_NOTA: y = ~a;
      LF_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/addend_gen.sv
module addend_gen
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  arith_fn_e      fn,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           cin
);

  // The second adder input and the carry-in together pick the operation
  always_comb begin
    unique case (fn)
      AF_ADD:  begin y = b;         cin = 1'b0; end
      AF_SUB:  begin y = ~b;        cin = 1'b1; end
      AF_INC:  begin y = '0;        cin = 1'b1; end
      AF_DEC:  begin y = {W{1'b1}}; cin = 1'b0; end
      default: begin y = '0;        cin = 1'b0; end
    endcase
  end

endmodule

// File: rtl/full_adder_cell.sv
module full_adder_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end

endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    full_adder_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign cout = chain[W];

endmodule

// File: rtl/dual_path_alu.sv
module dual_path_alu
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic [1:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         carry_out
);

  localparam int SW = W + 1;

  logic [W-1:0] lu_y;
  logic [W-1:0] ag_y;
  logic         ag_cin;
  logic [W-1:0] ad_sum;
  logic         ad_cout;
  logic [W-1:0] nxt_res;
  logic         nxt_c;

  bitwise_unit #(.W(W)) u_logic (
    .fn (logic_fn_e'(sel)),
    .a  (a),
    .b  (b),
    .y  (lu_y)
  );

  addend_gen #(.W(W)) u_addend (
    .fn  (arith_fn_e'(sel)),
    .b   (b),
    .y   (ag_y),
    .cin (ag_cin)
  );

  ripple_adder #(.W(W)) u_adder (
    .x    (a),
    .y    (ag_y),
    .cin  (ag_cin),
    .sum  (ad_sum),
    .cout (ad_cout)
  );

  // Path selector
  always_comb begin
    if (mode == MODE_ARITH) begin
      nxt_res = ad_sum;
      nxt_c   = ad_cout;
    end else begin
      nxt_res = lu_y;
      nxt_c   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_c;
    end
  end

  // R5 R6 R7 R8: adder output matches the arithmetic sum of its inputs
  adder_sum_chk: assert property (@(posedge clk) disable iff (rst)
    {ad_cout, ad_sum} == (SW'(a) + SW'(ag_y) + SW'(ag_cin)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0) && (carry_out == 1'b0));

  // R9
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOGIC) |=> (carry_out == 1'b0));

  // R1
  and_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOGIC && sel == 2'b00) |=> result == ($past(a) & $past(b)));

  // R3
  nota_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOGIC && sel == 2'b10) |=> result == ~$past(a));

  // R5
  add_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ARITH && sel == 2'b00) |=>
      {carry_out, result} == (SW'($past(a)) + SW'($past(b))));

  // R6
  sub_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ARITH && sel == 2'b01) |=>
      (result == W'($past(a) - $past(b))) && (carry_out == ($past(a) >= $past(b))));

  // R7
  inc_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ARITH && sel == 2'b10) |=>
      (result == W'($past(a) + 1'b1)) && (carry_out == (&$past(a))));

  // R8
  dec_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ARITH && sel == 2'b11) |=>
      (result == W'($past(a) - 1'b1)) && (carry_out == (|$past(a))));

endmodule

// File: tb/dual_path_alu_test.sv
module dual_path_alu_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode;
  logic [1:0]   sel;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_path_alu #(.W(W)) uut (
    .clk(clk), .rst(rst), .mode(mode), .sel(sel),
    .a(a), .b(b), .result(result), .carry_out(carry_out)
  );

  // {mode, sel, a, b, expected result, expected carry}
  localparam logic [15:0] VEC [0:12] = '{
    {1'b0, 2'b00, 4'hC, 4'hA, 4'h8, 1'b0},
    {1'b0, 2'b01, 4'hC, 4'hA, 4'hE, 1'b0},
    {1'b0, 2'b10, 4'h5, 4'hF, 4'hA, 1'b0},
    {1'b0, 2'b11, 4'hC, 4'hA, 4'h6, 1'b0},
    {1'b1, 2'b00, 4'h9, 4'h8, 4'h1, 1'b1},
    {1'b1, 2'b00, 4'h3, 4'h4, 4'h7, 1'b0},
    {1'b1, 2'b01, 4'h5, 4'h7, 4'hE, 1'b0},
    {1'b1, 2'b01, 4'h7, 4'h5, 4'h2, 1'b1},
    {1'b1, 2'b01, 4'h0, 4'h0, 4'h0, 1'b1},
    {1'b1, 2'b10, 4'hF, 4'h3, 4'h0, 1'b1},
    {1'b1, 2'b10, 4'h6, 4'h3, 4'h7, 1'b0},
    {1'b1, 2'b11, 4'h0, 4'h9, 4'hF, 1'b0},
    {1'b1, 2'b11, 4'h1, 4'h9, 4'h0, 1'b1}
  };

  function automatic string tag_of(input logic m, input logic [1:0] s);
    if (!m) begin
      case (s)
        2'b00:   return "R1";
        2'b01:   return "R2";
        2'b10:   return "R3";
        default: return "R4";
      endcase
    end
    case (s)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model written from the requirement text
  task automatic reference(input logic m, input logic [1:0] s,
                           input logic [W-1:0] x, input logic [W-1:0] y,
                           output logic [W-1:0] r, output logic c);
    int ix, iy;
    ix = int'(x);
    iy = int'(y);
    c  = 1'b0;
    if (!m) begin
      case (s)
        2'b00:   r = x & y;
        2'b01:   r = x | y;
        2'b10:   r = ~x;
        default: r = x ^ y;
      endcase
    end else begin
      case (s)
        2'b00: begin r = W'((ix + iy) % 16); c = (ix + iy) >= 16; end
        2'b01: begin r = W'((ix - iy + 16) % 16); c = ix >= iy; end
        2'b10: begin r = W'((ix + 1) % 16); c = ix == 15; end
        default: begin r = W'((ix + 15) % 16); c = ix != 0; end
      endcase
    end
  endtask

  task automatic check(input string req, input logic [W-1:0] got_r, input logic got_c,
                       input logic [W-1:0] exp_r, input logic exp_c);
    checks++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, got_r, got_c, exp_r, exp_c);
    end
  endtask

  // Called at a falling edge: drive, wait one full cycle, compare
  task automatic apply(input logic m, input logic [1:0] s,
                       input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [W-1:0] er, input logic ec, input string req);
    mode = m; sel = s; a = x; b = y;
    @(negedge clk);
    check(req, result, carry_out, er, ec);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: result=%h carry=%b expected completion", result, carry_out);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] er;
    logic         ec;
    rst = 1'b1; mode = 1'b1; sel = 2'b00; a = 4'hF; b = 4'hF;
    @(negedge clk);
    @(negedge clk);
    // R11: cleared by reset although inputs request 15+15
    check("R11", result, carry_out, 4'h0, 1'b0);
    rst = 1'b0;

    // Table of hand-picked vectors
    for (int i = 0; i < 13; i++) begin
      apply(VEC[i][15], VEC[i][14:13], VEC[i][12:9], VEC[i][8:5],
            VEC[i][4:1], VEC[i][0], tag_of(VEC[i][15], VEC[i][14:13]));
    end

    // Every mode, code and operand pair against the reference
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int x = 0; x < 16; x++) begin
          for (int y = 0; y < 16; y++) begin
            reference(m[0], s[1:0], x[3:0], y[3:0], er, ec);
            apply(m[0], s[1:0], x[3:0], y[3:0], er, ec,
                  (m == 0) ? {tag_of(m[0], s[1:0]), "/R9"} : tag_of(m[0], s[1:0]));
          end
        end
      end
    end

    // R3: b has no effect; same a, opposite b patterns give the same result
    apply(1'b0, 2'b10, 4'h6, 4'h0, 4'h9, 1'b0, "R3");
    apply(1'b0, 2'b10, 4'h6, 4'hF, 4'h9, 1'b0, "R3");

    // R9: a logic op right after an op that produced a carry
    apply(1'b1, 2'b10, 4'hF, 4'h0, 4'h0, 1'b1, "R7");
    apply(1'b0, 2'b01, 4'hF, 4'hF, 4'hF, 1'b0, "R9");

    // R10: input change between edges leaves the outputs unchanged
    apply(1'b1, 2'b00, 4'h8, 4'h8, 4'h0, 1'b1, "R5");
    mode = 1'b0; sel = 2'b00; a = 4'h3; b = 4'h5;
    #2;
    check("R10", result, carry_out, 4'h0, 1'b1);
    @(negedge clk);
    check("R10", result, carry_out, 4'h1, 1'b0);

    // R11: reset in the middle of traffic, with a carry-producing request
    apply(1'b1, 2'b11, 4'h5, 4'h0, 4'h4, 1'b1, "R8");
    rst = 1'b1; mode = 1'b1; sel = 2'b01; a = 4'h9; b = 4'h2;
    @(negedge clk);
    check("R11", result, carry_out, 4'h0, 1'b0);
    rst = 1'b0;
    apply(1'b1, 2'b01, 4'h9, 4'h2, 4'h7, 1'b1, "R6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule